// File: doc/BRIEF.md
# I2C Subaddressed Register Access Master

This block lets a host reach one 8-bit register inside an I2C device through a single 32-bit command. The command carries the transfer direction, a choice of read turnaround, the 7-bit device address, the 8-bit register subaddress and, for writes, the data byte. Once it has taken a command, the block drives the complete bus exchange on its own. A write sends START, the address with the write bit, the subaddress, the data and then STOP. A read sends START, the address with the write bit and the subaddress. It then turns the bus around with either a repeated START or a STOP followed by a fresh START. After that it sends the address with the read bit, takes in one byte, answers it with a NACK and ends with STOP.

The bus lines are open-drain. Each line is modelled as an output that pulls it low when set, plus an input that returns the wire level. Both inputs go through a synchronizer and a glitch filter before the controller uses them. After reset the controller waits until both lines are seen high. It then clears the bus with a START directly followed by a STOP, with no clock pulse between them, and only after that will it accept commands. A 32-bit status word reports:
- busy
- separate no-acknowledge flags for the address phase and the written-byte phase
- a read-complete flag together with the read byte
- an overrun flag
- the initializing state

Top module: `i2c_regxfer`

## Requirements
- R1: Command word fields: bit 31 = read (1) or write (0), bit 30 = use repeated START on a read, bits 22:16 = device address, bits 15:8 = subaddress, bits 7:0 = write data. A command written while idle is accepted. Status bit 31 (busy) is 1 on the next cycle, and status bits 30, 29, 28 and 27 clear.
- R2: A command written while busy sets status bit 27 (overrun) on the next cycle. That command is discarded and touches no device register. The flag clears on the next accepted command.
- R3: After reset, status reads 0x84000000 (busy, bit 26 initializing) and the SCL output is never pulled while initializing. Once both filtered lines read high, exactly one START and one STOP occur with no SCL falling edge between them. After that the status reads 0x00000000.
- R4: A write produces exactly one START and one STOP. It transfers three bytes MSB-first: address with R/W=0, subaddress, data. The data lands in the addressed device register. SCL is pulled only while busy, and both lines are released when busy falls.
- R5: A read with bit 30 set produces two STARTs and one STOP. It ends with status bit 28 set and the register contents in status bits 7:0.
- R6: A read with bit 30 clear produces two STARTs and two STOPs and returns the register contents in the same way.
- R7: A missing acknowledge after an address byte sets status bit 30, issues STOP at once with no further byte, leaves bit 28 clear and keeps the previous read byte in bits 7:0.
- R8: A missing acknowledge after the subaddress or data byte of a write sets status bit 29 with bit 30 clear.
- R9: On a read, command bits 7:0 have no effect: the addressed register keeps its value.
- R10: Status bits 25:8 always read 0, and command bits 29:23 have no effect on the transfer.
- R11: A low pulse shorter than the filter length on a line input is ignored. A line held low during initialization keeps status bit 26 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Command write strobe, one cycle |
| ctrl_wdata | input | 32 | Command word |
| status | output | 32 | Status word |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA wire level |

## Verification
Command acceptance and overrun detection can meet in consecutive cycles. The bench provokes this by writing a second command on the clock right after the first is taken. A per-clock model of the overrun flag, fed only by the strobe and the observed busy bit, is compared against status bit 27 on every cycle. The discarded command targets a different register, and the bench checks that this register is untouched. Address and data acknowledge failures each come from a behavioural device model on the bus. The end status must show exactly one failure flag and never a read-complete flag together with an address NACK.

// File: rtl/i2c_regxfer_pkg.sv
package i2c_regxfer_pkg;
  // command word fields
  localparam int CW_READ  = 31;
  localparam int CW_RSTRT = 30;
  localparam int CW_ADDR  = 16;
  localparam int CW_SUB   = 8;

  typedef enum logic [2:0] {
    ST_INIT, ST_BRST, ST_IDLE, ST_START, ST_BIT, ST_STOP
  } ctl_st_e;

  typedef enum logic [2:0] {
    SQ_AW, SQ_SUB, SQ_DAT, SQ_AR, SQ_RD
  } seq_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int LINES = 2,
  parameter int LEN   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_in,
  output logic [LINES-1:0] clean
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [1:0]    sync;
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk) begin
      if (rst) begin
        sync <= '0;
        cnt  <= '0;
        lvl  <= 1'b0;
      end else begin
        sync <= {sync[0], raw_in[i]};
        if (sync[1] == lvl) begin
          cnt <= '0;
        end else if (cnt == CW'(LEN - 1)) begin
          lvl <= sync[1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign clean[i] = lvl;
  end
endmodule

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int DIV = 62
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV < 2) ? 1 : $clog2(DIV);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == W'(DIV - 1));
      cnt  <= (cnt == W'(DIV - 1)) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_regxfer.sv
module i2c_regxfer
  import i2c_regxfer_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SCL_HZ   = 400_000,
  parameter int FILT_LEN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output logic [31:0] status,
  output logic        scl_oe,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe
);
  localparam int QRAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QDIV = (QRAW < 2) ? 2 : QRAW;

  logic [1:0] filt;
  logic       scl_f, sda_f, qtick;

  i2c_line_filter #(.LINES(2), .LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .raw_in({scl_in, sda_in}), .clean(filt)
  );
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  i2c_quarter_tick #(.DIV(QDIV)) u_tick (.clk(clk), .rst(rst), .tick(qtick));

  ctl_st_e    st;
  seq_e       sq;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, rdata, c_sub, c_dat;
  logic [6:0] c_addr;
  logic       c_rd, c_rs, nack, again;
  logic       f_anack, f_dnack, f_rd, f_ovr;
  logic       unused_rsvd;

  assign unused_rsvd = ^ctrl_wdata[29:23];

  assign status = {st != ST_IDLE, f_anack, f_dnack, f_rd, f_ovr,
                   (st == ST_INIT) || (st == ST_BRST), 18'd0, rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_INIT;  sq <= SQ_AW;  q <= '0;  bitn <= '0;
      sh <= '0;  rdata <= '0;  c_sub <= '0;  c_dat <= '0;  c_addr <= '0;
      c_rd <= 1'b0;  c_rs <= 1'b0;  nack <= 1'b0;  again <= 1'b0;
      f_anack <= 1'b0;  f_dnack <= 1'b0;  f_rd <= 1'b0;  f_ovr <= 1'b0;
      scl_oe <= 1'b0;  sda_oe <= 1'b0;
    end else begin
      if (qtick) begin
        q <= q + 2'd1;
        unique case (st)
          ST_INIT: begin
            q <= '0;
            if (scl_f && sda_f) st <= ST_BRST;
          end
          ST_BRST: begin
            // START then STOP while SCL stays released
            if (q == 2'd1) sda_oe <= 1'b1;
            if (q == 2'd2) sda_oe <= 1'b0;
            if (q == 2'd3) st <= ST_IDLE;
          end
          ST_IDLE: q <= '0;
          ST_START: begin
            unique case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1;
                st     <= ST_BIT;
                bitn   <= '0;
                sh     <= {c_addr, sq == SQ_AR};
              end
            endcase
          end
          ST_BIT: begin
            unique case (q)
              2'd0: sda_oe <= (sq != SQ_RD) && (bitn != 4'd8) && !sh[7];
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) nack <= sda_f;
                else sh <= {sh[6:0], sda_f};
              end
              default: begin
                scl_oe <= 1'b1;
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                end else begin
                  bitn <= '0;
                  unique case (sq)
                    SQ_AW, SQ_AR: begin
                      if (nack) begin
                        f_anack <= 1'b1;
                        st      <= ST_STOP;
                      end else begin
                        sq <= (sq == SQ_AW) ? SQ_SUB : SQ_RD;
                        sh <= (sq == SQ_AW) ? c_sub : 8'h00;
                      end
                    end
                    SQ_SUB: begin
                      if (nack) begin
                        f_dnack <= 1'b1;
                        st      <= ST_STOP;
                      end else if (!c_rd) begin
                        sq <= SQ_DAT;
                        sh <= c_dat;
                      end else if (c_rs) begin
                        sq <= SQ_AR;
                        st <= ST_START;
                      end else begin
                        again <= 1'b1;
                        st    <= ST_STOP;
                      end
                    end
                    SQ_DAT: begin
                      f_dnack <= nack;
                      st      <= ST_STOP;
                    end
                    default: begin
                      rdata <= sh;
                      f_rd  <= 1'b1;
                      st    <= ST_STOP;
                    end
                  endcase
                end
              end
            endcase
          end
          default: begin // ST_STOP
            unique case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                if (again) begin
                  again <= 1'b0;
                  sq    <= SQ_AR;
                  st    <= ST_START;
                end else begin
                  st <= ST_IDLE;
                end
              end
            endcase
          end
        endcase
      end

      if (ctrl_wr) begin
        if (st != ST_IDLE) begin
          f_ovr <= 1'b1;
        end else begin
          c_rd    <= ctrl_wdata[CW_READ];
          c_rs    <= ctrl_wdata[CW_RSTRT];
          c_addr  <= ctrl_wdata[CW_ADDR +: 7];
          c_sub   <= ctrl_wdata[CW_SUB +: 8];
          c_dat   <= ctrl_wdata[7:0];
          f_ovr   <= 1'b0;
          f_anack <= 1'b0;
          f_dnack <= 1'b0;
          f_rd    <= 1'b0;
          again   <= 1'b0;
          sq      <= SQ_AW;
          q       <= '0;
          st      <= ST_START;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regxfer_chk.sv
module i2c_regxfer_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic [31:0] status,
  input logic        scl_oe,
  input logic        sda_oe
);
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !status[31] |=> status[31] && !status[30] && !status[29] && !status[28] && !status[27]);

  p_overrun_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && status[31] |=> status[27]);

  p_init_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    status[26] |-> !scl_oe);

  p_scl_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> status[31]);

  p_release_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(status[31]) |-> !scl_oe && !sda_oe);

  p_read_vs_anack_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(status[31]) |-> !(status[28] && status[30]));
endmodule

bind i2c_regxfer i2c_regxfer_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .status(status),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/test_i2c_regxfer.sv
module test_i2c_regxfer;
  logic        clk = 1'b0, rst = 1'b1, ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  wire  [31:0] status;
  wire         scl_oe, sda_oe;
  logic        s_hold = 1'b1, s_drv = 1'b0;
  wire         scl_w = ~scl_oe;
  wire         sda_w = ~(sda_oe | s_drv | s_hold);

  i2c_regxfer #(.CLK_HZ(32_000_000), .SCL_HZ(1_000_000), .FILT_LEN(4)) i_i2c_regxfer (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .status(status),
    .scl_oe(scl_oe), .scl_in(scl_w), .sda_in(sda_w), .sda_oe(sda_oe)
  );

  always #2 clk = ~clk; // 250 MHz

  int checks = 0, fails = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural device at address 0x50
  localparam logic [6:0] SADDR = 7'h50;
  logic [7:0] mem [256];
  logic [7:0] sl_sh, sl_tx, sl_ptr;
  int  sl_bc = 0, sl_ph = 3;
  bit  sl_rd, sl_pend, sl_ack, nack_data;
  int  starts, stops, scl_falls, bytes_seen;

  always @(negedge sda_w) if (scl_w) begin
    starts++; sl_bc = 0; sl_ph = 0; sl_rd = 0; sl_pend = 0; s_drv = 0;
  end
  always @(posedge sda_w) if (scl_w) begin
    stops++; sl_ph = 3; sl_rd = 0; s_drv = 0;
  end
  always @(posedge scl_w) if (sl_ph != 3) begin
    if (sl_bc < 8) begin
      if (!sl_rd) sl_sh = {sl_sh[6:0], sda_w};
      sl_bc++;
    end else sl_bc = 9;
  end
  always @(negedge scl_w) begin
    scl_falls++;
    if (sl_ph != 3) begin
      if (sl_bc == 8) begin
        if (sl_rd) s_drv = 0;
        else begin
          bytes_seen++; sl_ack = 0;
          case (sl_ph)
            0: if (sl_sh[7:1] == SADDR) begin
                 sl_ack = 1;
                 if (sl_sh[0]) begin sl_pend = 1; sl_tx = mem[sl_ptr]; end
                 else sl_ph = 1;
               end
            1: begin sl_ptr = sl_sh; sl_ack = 1; sl_ph = 2; end
            default: if (!nack_data) begin mem[sl_ptr] = sl_sh; sl_ack = 1; end
          endcase
          s_drv = sl_ack;
        end
      end else if (sl_bc == 9) begin
        sl_bc = 0; s_drv = 0;
        if (sl_pend) begin sl_pend = 0; sl_rd = 1; s_drv = !sl_tx[7]; end
      end else if (sl_rd && sl_bc >= 1 && sl_bc <= 7) begin
        s_drv = !sl_tx[7 - sl_bc];
      end
    end
  end

  // per-clock reference for the overrun flag and the reserved bits
  logic exp_ovr = 1'b0;
  always @(posedge clk) begin
    if (rst) exp_ovr <= 1'b0;
    else if (ctrl_wr) exp_ovr <= status[31];
  end
  always @(negedge clk) if (!rst) begin
    check("R2 overrun flag per clock", {31'd0, status[27]}, {31'd0, exp_ovr});
    check("R10 status 25:8 zero", {14'd0, status[25:8]}, 32'd0);
  end

  function automatic logic [31:0] cmd(bit rd, bit rs, logic [6:0] a, logic [7:0] s, logic [7:0] d);
    return {rd, rs, 7'd0, a, s, d};
  endfunction

  task automatic clr();
    starts = 0; stops = 0; scl_falls = 0; bytes_seen = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    while (status[31] && n < 20000) begin @(negedge clk); n++; end
    check({req, " completes"}, {31'd0, status[31]}, 32'd0);
  endtask

  task automatic issue(input logic [31:0] w, input bit dup, input logic [31:0] w2, input string req);
    @(negedge clk);
    clr();
    ctrl_wdata = w; ctrl_wr = 1'b1;
    @(negedge clk);
    check("R1 busy after accept", {31'd0, status[31]}, 32'd1);
    if (dup) begin
      ctrl_wdata = w2;
      @(negedge clk);
    end
    ctrl_wr = 1'b0;
    wait_idle(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h40] = 8'h81;
    nack_data = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset status", status, 32'h8400_0000);
    clr();
    repeat (40) @(negedge clk);
    check("R3 waits while SDA low", status, 32'h8400_0000);
    check("R3 no SCL activity in init", scl_falls, 0);
    // short release shorter than filter
    s_hold = 1'b0;
    @(negedge clk); @(negedge clk);
    s_hold = 1'b1;
    repeat (40) @(negedge clk);
    check("R11 glitch ignored, still init", {31'd0, status[26]}, 32'd1);
    s_hold = 1'b0;
    @(negedge clk);
    clr();
    wait_idle("R3 init");
    check("R3 bus reset starts", starts, 1);
    check("R3 bus reset stops", stops, 1);
    check("R3 no SCL pulse in bus reset", scl_falls, 0);
    check("R3 idle status", status, 32'h0000_0000);

    // write with reserved bits set, second command during busy
    issue(cmd(0, 0, SADDR, 8'h12, 8'hA5) | 32'h3F80_0000, 1, cmd(0, 0, SADDR, 8'h13, 8'h77), "R4 write");
    check("R4 register written", {24'd0, mem[8'h12]}, 32'h0000_00A5);
    check("R2 discarded command", {24'd0, mem[8'h13]}, 32'h0000_0000);
    check("R2 R4 status after write", status, 32'h0800_0000);
    check("R4 one start", starts, 1);
    check("R4 one stop", stops, 1);
    check("R4 three bytes", bytes_seen, 3);

    issue(cmd(1, 1, SADDR, 8'h12, 8'h3C), 0, 0, "R5 read");
    check("R5 R2 status after repeated-start read", status, 32'h1000_00A5);
    check("R5 two starts", starts, 2);
    check("R5 one stop", stops, 1);
    check("R9 register kept on read", {24'd0, mem[8'h12]}, 32'h0000_00A5);

    issue(cmd(1, 0, SADDR, 8'h40, 8'h00), 0, 0, "R6 read");
    check("R6 status after stop-start read", status, 32'h1000_0081);
    check("R6 two starts", starts, 2);
    check("R6 two stops", stops, 2);

    issue(cmd(0, 0, 7'h51, 8'h12, 8'h11), 0, 0, "R7 write");
    check("R7 address nack status", status, 32'h4000_0081);
    check("R7 no byte after address", bytes_seen, 1);
    check("R7 one stop", stops, 1);
    check("R7 register untouched", {24'd0, mem[8'h12]}, 32'h0000_00A5);

    issue(cmd(1, 1, 7'h51, 8'h12, 8'h00), 0, 0, "R7 read");
    check("R7 read address nack status", status, 32'h4000_0081);

    nack_data = 1;
    issue(cmd(0, 0, SADDR, 8'h20, 8'h5A), 0, 0, "R8 write");
    nack_data = 0;
    check("R8 data nack status", status, 32'h2000_0081);
    check("R8 register untouched", {24'd0, mem[8'h20]}, 32'h0000_0000);

    issue(cmd(1, 1, SADDR, 8'h12, 8'h00), 0, 0, "R1 read");
    check("R1 flags cleared by new command", status, 32'h1000_00A5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule